// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block decides when a data converter core and its internal reference receive power, and when the core is settled enough to accept a conversion. It takes a two-bit power policy and a reference-disable bit straight from the configuration logic. It also watches the chip-select level, a conversion-start request and a conversion-done pulse. From these it drives a core power enable, a reference power enable and a ready flag.

Four policies are supported. In the first, chip select controls power: the core is on while chip select is low. In the second, the core is never switched off. In the third, the core shuts down fully after every conversion. In the fourth, the core drops to a standby state after every conversion, and in that state the reference stays up.

Wake-up times are counted in system clock cycles. A full power-up and a wake from standby each have their own count. A start request that arrives before the core is ready is still forwarded to the core, but it is marked as invalid so that the hazard can be seen.

Top module: `pms_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0. The sequencer starts in the powered-off state with the chip-select-driven policy behaviour.
- R2: With `pm_mode_i` = 2'b00, core power turns on one cycle after `cs_n_i` is sampled low. Whenever `cs_n_i` is sampled high, `core_pwr_o` and `ready_o` are 0 on the next cycle, whatever state the sequencer is in. When a conversion finishes with `cs_n_i` low, the sequencer returns to ready.
- R3: With `pm_mode_i` = 2'b01, the core powers up without any chip-select activity. It stays powered and ready across chip-select toggles and after conversions.
- R4: With `pm_mode_i` = 2'b10, a done pulse during a conversion turns both core and reference power off. A later falling edge of `cs_n_i` starts a full wake-up. A rising edge of `cs_n_i` has no effect on power or ready.
- R5: With `pm_mode_i` = 2'b11, a done pulse during a conversion turns core power off and leaves `ref_pwr_o` at 1 when `ref_dis_i` is 0. A falling edge of `cs_n_i` wakes the core from this standby state.
- R6: After a wake from the fully off state, `core_pwr_o` is 1 with `ready_o` at 0 for exactly FULL_WAKE_CYC cycles, and then `ready_o` rises. `ready_o` is never 1 while `core_pwr_o` is 0.
- R7: A wake from standby holds `ready_o` low for exactly STBY_WAKE_CYC cycles while the core is powered.
- R8: `ref_pwr_o` is 1 only when `ref_dis_i` was 0 at the previous clock edge and the sequencer is not fully off. A 1 on `ref_dis_i` forces it to 0 on the next cycle.
- R9: A `conv_start_i` sampled while ready sets `conv_go_o` = 1 and `start_invalid_o` = 0 on the next cycle, and `ready_o` drops until the conversion finishes.
- R10: A `conv_start_i` sampled while not ready and not converting sets both `conv_go_o` and `start_invalid_o` on the next cycle. It does not change the state, so a wake-up in progress continues with its remaining count.
- R11: A `conv_start_i` during a conversion produces no `conv_go_o`. A `conv_done_i` outside a conversion has no effect.
- R12: A change of `pm_mode_i` takes effect at the next edge. Selecting 2'b01 from the off state starts a wake-up. Selecting 2'b00 while `cs_n_i` is high powers the core and reference off. Selecting 2'b10 or 2'b11 while ready leaves the block ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_mode_i | input | 2 | Power policy: 00 chip-select driven, 01 always on, 10 shutdown after conversion, 11 standby after conversion |
| ref_dis_i | input | 1 | 1 disables the internal reference |
| cs_n_i | input | 1 | Chip-select level, active low |
| conv_start_i | input | 1 | Conversion-start request |
| conv_done_i | input | 1 | Conversion-complete pulse from the core |
| core_pwr_o | output | 1 | Core power enable |
| ref_pwr_o | output | 1 | Reference power enable |
| ready_o | output | 1 | Core settled; conversions may start |
| conv_go_o | output | 1 | Start forwarded to the core |
| start_invalid_o | output | 1 | Forwarded start came before the core was ready |

## Verification
The bench measures the exact length of every wake-up window. It measures one from the fully off state and one from standby, including a standby wake with the reference disabled. A design that swapped the counts, or was off by one, would raise ready a cycle early or late, or use the wrong delay. It also fires a start in the middle of a wake-up, and checks that the start is forwarded and flagged while the remaining delay stays exactly as it was; a design that restarted the count or jumped to converting would fail there. Further cases cover chip-select rising in the post-conversion policies, which must be ignored, and policy changes while the core is off or ready. A design that evaluated the policy only at conversion end would keep the core powered after a switch to chip-select control with chip select high.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_WAKING = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_CONV   = 3'd3,
    ST_STBY   = 3'd4
  } pms_state_e;

  typedef enum logic [1:0] {
    PM_CS_TIED  = 2'b00,
    PM_ALWAYS   = 2'b01,
    PM_SHUTDOWN = 2'b10,
    PM_STANDBY  = 2'b11
  } pm_mode_e;

  // Decoded view of one power policy
  typedef struct packed {
    logic       level_ctl;   // policy holds power from a level, not an event
    logic       want_on;     // level policies: power requested now
    logic       wake_evt;    // condition that starts a wake from off/standby
    pms_state_e rest_state;  // where a finished conversion lands
  } pms_policy_t;

endpackage

// File: rtl/pms_policy.sv
module pms_policy
  import pms_pkg::*;
(
  input  logic [1:0]  mode_i,
  input  logic        cs_n_i,
  input  logic        cs_fall_i,
  output pms_policy_t pol_o
);

  always_comb begin
    pol_o = '{level_ctl: 1'b1, want_on: 1'b0, wake_evt: 1'b0, rest_state: ST_ACTIVE};
    unique case (pm_mode_e'(mode_i))
      PM_CS_TIED: begin
        pol_o.level_ctl  = 1'b1;
        pol_o.want_on    = ~cs_n_i;
        pol_o.wake_evt   = ~cs_n_i;
        pol_o.rest_state = ST_ACTIVE;
      end
      PM_ALWAYS: begin
        pol_o.level_ctl  = 1'b1;
        pol_o.want_on    = 1'b1;
        pol_o.wake_evt   = 1'b1;
        pol_o.rest_state = ST_ACTIVE;
      end
      PM_SHUTDOWN: begin
        pol_o.level_ctl  = 1'b0;
        pol_o.want_on    = 1'b0;
        pol_o.wake_evt   = cs_fall_i;
        pol_o.rest_state = ST_OFF;
      end
      PM_STANDBY: begin
        pol_o.level_ctl  = 1'b0;
        pol_o.want_on    = 1'b0;
        pol_o.wake_evt   = cs_fall_i;
        pol_o.rest_state = ST_STBY;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pms_wake_timer.sv
module pms_wake_timer #(
  parameter int FULL_WAKE_CYC = 1250,
  parameter int STBY_WAKE_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic short_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int MAX_CYC = (FULL_WAKE_CYC > STBY_WAKE_CYC) ? FULL_WAKE_CYC : STBY_WAKE_CYC;
  localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CW-1:0] FULL_LD = CW'(FULL_WAKE_CYC - 1);
  localparam logic [CW-1:0] STBY_LD = CW'(STBY_WAKE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= short_i ? STBY_LD : FULL_LD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pms_seq.sv
module pms_seq
  import pms_pkg::*;
#(
  parameter int FULL_WAKE_CYC = 1250,
  parameter int STBY_WAKE_CYC = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pm_mode_i,
  input  logic       ref_dis_i,
  input  logic       cs_n_i,
  input  logic       conv_start_i,
  input  logic       conv_done_i,
  output logic       core_pwr_o,
  output logic       ref_pwr_o,
  output logic       ready_o,
  output logic       conv_go_o,
  output logic       start_invalid_o
);

  pms_state_e  state_q, state_d;
  pms_policy_t pol;
  logic        cs_n_q;
  logic        cs_fall;
  logic        tmr_load, tmr_short, tmr_expired;

  assign cs_fall = cs_n_q & ~cs_n_i;

  pms_policy u_policy (
    .mode_i    (pm_mode_i),
    .cs_n_i    (cs_n_i),
    .cs_fall_i (cs_fall),
    .pol_o     (pol)
  );

  pms_wake_timer #(
    .FULL_WAKE_CYC (FULL_WAKE_CYC),
    .STBY_WAKE_CYC (STBY_WAKE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .short_i   (tmr_short),
    .run_i     (state_q == ST_WAKING),
    .expired_o (tmr_expired)
  );

  // Next-state logic: a level policy asking for power off wins over everything
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_short = 1'b0;
    if (pol.level_ctl && !pol.want_on) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: if (pol.wake_evt) begin
          state_d  = ST_WAKING;
          tmr_load = 1'b1;
        end
        ST_STBY: if (pol.wake_evt) begin
          state_d   = ST_WAKING;
          tmr_load  = 1'b1;
          tmr_short = 1'b1;
        end
        ST_WAKING: if (tmr_expired) state_d = ST_ACTIVE;
        ST_ACTIVE: if (conv_start_i) state_d = ST_CONV;
        ST_CONV:   if (conv_done_i) state_d = pol.rest_state;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_OFF;
      cs_n_q          <= 1'b1;
      core_pwr_o      <= 1'b0;
      ref_pwr_o       <= 1'b0;
      ready_o         <= 1'b0;
      conv_go_o       <= 1'b0;
      start_invalid_o <= 1'b0;
    end else begin
      state_q         <= state_d;
      cs_n_q          <= cs_n_i;
      core_pwr_o      <= (state_d == ST_WAKING) || (state_d == ST_ACTIVE) || (state_d == ST_CONV);
      ref_pwr_o       <= !ref_dis_i && (state_d != ST_OFF);
      ready_o         <= (state_d == ST_ACTIVE);
      conv_go_o       <= conv_start_i && (state_q != ST_CONV);
      start_invalid_o <= conv_start_i && (state_q != ST_CONV) && (state_q != ST_ACTIVE);
    end
  end

endmodule

// File: rtl/pms_seq_chk.sv
module pms_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pm_mode_i,
  input logic       ref_dis_i,
  input logic       cs_n_i,
  input logic       conv_start_i,
  input logic       core_pwr_o,
  input logic       ref_pwr_o,
  input logic       ready_o,
  input logic       conv_go_o,
  input logic       start_invalid_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!core_pwr_o && !ref_pwr_o && !ready_o && !conv_go_o && !start_invalid_o));

  assert_cs_high_off_R2: assert property (@(posedge clk) disable iff (rst)
    (pm_mode_i == 2'b00 && cs_n_i) |=> (!core_pwr_o && !ready_o));

  assert_always_on_R3: assert property (@(posedge clk) disable iff (rst)
    (pm_mode_i == 2'b01 && core_pwr_o) |=> core_pwr_o);

  assert_ready_powered_R6: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> core_pwr_o);

  assert_ready_after_power_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(core_pwr_o));

  assert_ref_gate_R8: assert property (@(posedge clk) disable iff (rst)
    ref_dis_i |=> !ref_pwr_o);

  assert_go_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    conv_go_o |-> $past(conv_start_i));

  assert_invalid_forwarded_R10: assert property (@(posedge clk) disable iff (rst)
    start_invalid_o |-> conv_go_o);

endmodule

bind pms_seq pms_seq_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .pm_mode_i       (pm_mode_i),
  .ref_dis_i       (ref_dis_i),
  .cs_n_i          (cs_n_i),
  .conv_start_i    (conv_start_i),
  .core_pwr_o      (core_pwr_o),
  .ref_pwr_o       (ref_pwr_o),
  .ready_o         (ready_o),
  .conv_go_o       (conv_go_o),
  .start_invalid_o (start_invalid_o)
);

// File: tb/pms_seq_test.sv
module pms_seq_test;

  localparam int FULL = 24;
  localparam int STBY = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pm_mode = 2'b00;
  logic       ref_dis = 1'b0;
  logic       cs_n = 1'b1;
  logic       start = 1'b0;
  logic       done = 1'b0;
  logic       core_pwr, ref_pwr, ready, go, invalid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pms_seq #(.FULL_WAKE_CYC(FULL), .STBY_WAKE_CYC(STBY)) uut (
    .clk             (clk),
    .rst             (rst),
    .pm_mode_i       (pm_mode),
    .ref_dis_i       (ref_dis),
    .cs_n_i          (cs_n),
    .conv_start_i    (start),
    .conv_done_i     (done),
    .core_pwr_o      (core_pwr),
    .ref_pwr_o       (ref_pwr),
    .ready_o         (ready),
    .conv_go_o       (go),
    .start_invalid_o (invalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Counts the cycles with core powered and not ready until ready rises
  task automatic measure_wake(output int n);
    n = 0;
    for (int i = 0; i < 4 * FULL + 8; i++) begin
      @(negedge clk);
      if (ready) break;
      if (core_pwr) n++;
    end
  endtask

  task automatic pulse_start;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_done;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expect_eq("R1 core in reset", core_pwr, 0);
    expect_eq("R1 ready in reset", ready, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1 core after reset", core_pwr, 0);
    expect_eq("R1 ref after reset", ref_pwr, 0);
    expect_eq("R1 go after reset", go, 0);
  endtask

  task automatic t_cs_tied;
    int n;
    pm_mode = 2'b00;
    cs_n = 1'b0;
    measure_wake(n);
    expect_eq("R2/R6 full wake length", n, FULL);
    expect_eq("R8 ref on", ref_pwr, 1);
    pulse_start();
    expect_eq("R9 go", go, 1);
    expect_eq("R9 invalid", invalid, 0);
    expect_eq("R9 ready low converting", ready, 0);
    pulse_start();
    expect_eq("R11 start while converting", go, 0);
    pulse_done();
    expect_eq("R2 back to ready after done", ready, 1);
    pulse_done();
    expect_eq("R11 stray done ignored", ready, 1);
    cs_n = 1'b1;
    @(negedge clk);
    expect_eq("R2 cs high core off", core_pwr, 0);
    expect_eq("R2 cs high ready off", ready, 0);
  endtask

  task automatic t_early_start;
    int n;
    pm_mode = 2'b00;
    cs_n = 1'b0;
    @(negedge clk);
    pulse_start();
    expect_eq("R10 early go", go, 1);
    expect_eq("R10 early invalid", invalid, 1);
    expect_eq("R10 still waking", core_pwr & ~ready, 1);
    measure_wake(n);
    expect_eq("R10 remaining wake", n, FULL - 2);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_always;
    int n;
    pm_mode = 2'b01;
    measure_wake(n);
    expect_eq("R3/R12 wake with no cs", n, FULL);
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    expect_eq("R3 cs toggle ignored", ready, 1);
    pulse_start();
    pulse_done();
    expect_eq("R3 powered after conversion", core_pwr, 1);
    expect_eq("R3 ready after conversion", ready, 1);
  endtask

  task automatic t_shutdown;
    int n;
    pm_mode = 2'b10;
    @(negedge clk);
    expect_eq("R12 switch to shutdown keeps ready", ready, 1);
    pulse_start();
    pulse_done();
    expect_eq("R4 core off after done", core_pwr, 0);
    expect_eq("R4 ref off after done", ref_pwr, 0);
    cs_n = 1'b0;
    measure_wake(n);
    expect_eq("R4/R6 full wake on cs fall", n, FULL);
    cs_n = 1'b1;
    @(negedge clk);
    expect_eq("R4 cs rise ignored", ready, 1);
  endtask

  task automatic t_standby;
    int n;
    pm_mode = 2'b11;
    pulse_start();
    pulse_done();
    expect_eq("R5 core off in standby", core_pwr, 0);
    expect_eq("R5 ref kept in standby", ref_pwr, 1);
    cs_n = 1'b0;
    measure_wake(n);
    expect_eq("R7 standby wake length", n, STBY);
    ref_dis = 1'b1;
    @(negedge clk);
    expect_eq("R8 ref disabled", ref_pwr, 0);
    expect_eq("R8 core unaffected", core_pwr, 1);
    pulse_start();
    pulse_done();
    expect_eq("R8 ref off in standby when disabled", ref_pwr, 0);
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    measure_wake(n);
    expect_eq("R7 standby wake with ref off", n, STBY);
    ref_dis = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_switch_to_cs;
    cs_n = 1'b1;
    @(negedge clk);
    expect_eq("R5 cs level ignored in standby policy", ready, 1);
    pm_mode = 2'b00;
    @(negedge clk);
    expect_eq("R12 switch to cs policy core off", core_pwr, 0);
    expect_eq("R12 switch to cs policy ref off", ref_pwr, 0);
    expect_eq("R12 switch to cs policy ready off", ready, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cs_tied();
    t_early_start();
    t_always();
    t_shutdown();
    t_standby();
    t_switch_to_cs();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule